// File: doc/BRIEF.md
# Octal PSRAM Mode-Register Bring-Up Sequencer

After reset, this block configures and identifies an octal pseudo-SRAM device. It does not drive the memory bus itself. It issues register transactions through a request port to a bus sequencer and waits for that sequencer to report completion.

First it updates the latency type, read latency and drive strength fields of mode register 0 with a read-modify-write, so the other bits keep their values. When error correction is enabled at build time, it does the same for the burst length and burst type fields of mode register 8.

It then reads back the identification registers and checks the vendor code. It decodes the density code into a physical size in bytes and reports a usable size. With error correction on, the usable size is 15/16 of the physical size, because the check bytes take the rest. It also reports the read latency in clock cycles, taken from the read-back latency code. All results stay fixed until the next reset.

Top module: `psram_mr_init`

## Requirements
- R1: While `rst_n` is low, `init_done`, `init_err`, `phys_bytes`, `avail_bytes` and `rd_lat_cycles` are all 0. The first transaction after reset is a 16-bit read (`req_write`=0, `req_wide`=1) at address 0.
- R2: The second transaction is a 16-bit write at address 0. Its low byte is the low byte just read, with bits [5:0] replaced by `{LAT_FIXED, RD_LAT_CODE, DRV_STR}` (bit 5, bits [4:2], bits [1:0]); with default parameters those bits are 0x28. Bits [7:6] are kept. Its high byte is the high byte just read, unchanged.
- R3: When `ECC_EN`=1, the next transaction is an 8-bit read at address 8. It is followed by an 8-bit write at address 8 with data `{rd[7:3], BURST_TYPE, BURST_LEN}`, which is `{rd[7:3], 3'b011}` by default, and a zero high byte. When `ECC_EN`=0, these two transactions are not issued.
- R4: The identification reads follow in this order: a 16-bit read at 0, a 16-bit read at 2, an 8-bit read at 4, and an 8-bit read at 8.
- R5: `req_start` is a one-cycle pulse issued once per transaction. No new pulse is issued until `rsp_done` has been seen in a cycle after the pulse, and `rsp_rdata` is captured in that same cycle. A completed run therefore issues exactly 8 pulses with `ECC_EN`=1 and exactly 6 with `ECC_EN`=0.
- R6: The vendor code is bits [12:8] of the 16-bit read-back at address 0. If it differs from `VENDOR_ID` (default 0xD), `init_err` and `init_done` are both set and both sizes are 0.
- R7: The density code is bits [2:0] of the 16-bit read-back at address 2. Codes 1, 3, 5 and 7 give 4, 8, 16 and 32 MiB in `phys_bytes`; any other code gives 0.
- R8: `avail_bytes` equals `phys_bytes - phys_bytes/16` when `ECC_EN`=1, and equals `phys_bytes` otherwise.
- R9: At completion, `rd_lat_cycles` equals the read-back latency code (bits [4:2] at address 0) times 2 plus 6.
- R10: Once set, `init_done` and `init_err` stay set until reset. After completion, no further request is issued, and `rsp_done` pulses leave every output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_start | output | 1 | One-cycle pulse that launches a register transaction |
| req_write | output | 1 | 1 for a register write, 0 for a register read |
| req_wide | output | 1 | 1 for a 16-bit access, 0 for an 8-bit access |
| req_addr | output | AW | Register address |
| req_wdata | output | 16 | Write data (register at the address in the low byte, the next register in the high byte) |
| rsp_done | input | 1 | Sequencer reports that the transaction has completed |
| rsp_rdata | input | 16 | Read data, valid while `rsp_done` is high |
| init_done | output | 1 | Sticky completion flag |
| init_err | output | 1 | Sticky unsupported-device flag |
| phys_bytes | output | SZW | Decoded physical size in bytes |
| avail_bytes | output | SZW | Usable size in bytes |
| rd_lat_cycles | output | 5 | Read latency in cycles, from the read-back latency code |

## Verification
Two instances run side by side, one with error correction and one without, each attached to a bench register model that answers after a random delay. Every density code is run with the correct vendor code, which separates the four valid sizes from the invalid codes, and the error-corrected sizes from the plain ones. Wrong vendor codes check that an error clears the sizes. Random register contents for the reserved bits show whether the read-modify-write keeps bits it must not touch. Stray completion pulses after the end show whether the results really stay fixed.

// File: rtl/psram_mr_init.sv
module psram_mr_init #(
  parameter bit       ECC_EN      = 1'b1,
  parameter bit [4:0] VENDOR_ID   = 5'hD,
  parameter bit       LAT_FIXED   = 1'b1,
  parameter bit [2:0] RD_LAT_CODE = 3'd2,
  parameter bit [1:0] DRV_STR     = 2'd0,
  parameter bit [1:0] BURST_LEN   = 2'd3,
  parameter bit       BURST_TYPE  = 1'b0,
  parameter int       AW          = 8,
  parameter int       SZW         = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  output logic           req_start,
  output logic           req_write,
  output logic           req_wide,
  output logic [AW-1:0]  req_addr,
  output logic [15:0]    req_wdata,
  input  logic           rsp_done,
  input  logic [15:0]    rsp_rdata,
  output logic           init_done,
  output logic           init_err,
  output logic [SZW-1:0] phys_bytes,
  output logic [SZW-1:0] avail_bytes,
  output logic [4:0]     rd_lat_cycles
);

  localparam logic [7:0] CFG0_MASK = 8'h3F;
  localparam logic [7:0] CFG0_SET  = {2'b00, LAT_FIXED, RD_LAT_CODE, DRV_STR};
  localparam logic [7:0] CFG8_MASK = 8'h07;
  localparam logic [7:0] CFG8_SET  = {5'b0, BURST_TYPE, BURST_LEN};

  typedef enum logic [3:0] {
    ST_RD0, ST_WR0, ST_RD8, ST_WR8, ST_ID01, ST_ID23, ST_ID4, ST_ID8, ST_FIN
  } step_t;

  step_t       step, step_nxt;
  logic        busy;
  logic [15:0] held;
  logic [4:0]  vid;
  logic [2:0]  dens;
  logic [2:0]  lat_code;

  function automatic logic [SZW-1:0] size_of(input logic [2:0] code);
    case (code)
      3'd1:    size_of = SZW'(32'h0040_0000);
      3'd3:    size_of = SZW'(32'h0080_0000);
      3'd5:    size_of = SZW'(32'h0100_0000);
      3'd7:    size_of = SZW'(32'h0200_0000);
      default: size_of = '0;
    endcase
  endfunction

  assign req_start = (step != ST_FIN) && !busy;

  always_comb begin
    req_write = 1'b0;
    req_wide  = 1'b0;
    req_addr  = '0;
    req_wdata = '0;
    step_nxt  = ST_FIN;
    case (step)
      ST_RD0:  begin req_wide = 1'b1; step_nxt = ST_WR0; end
      ST_WR0:  begin
        req_write = 1'b1;
        req_wide  = 1'b1;
        req_wdata = {held[15:8], (held[7:0] & ~CFG0_MASK) | CFG0_SET};
        step_nxt  = ECC_EN ? ST_RD8 : ST_ID01;
      end
      ST_RD8:  begin req_addr = AW'(8); step_nxt = ST_WR8; end
      ST_WR8:  begin
        req_write = 1'b1;
        req_addr  = AW'(8);
        req_wdata = {8'h00, (held[7:0] & ~CFG8_MASK) | CFG8_SET};
        step_nxt  = ST_ID01;
      end
      ST_ID01: begin req_wide = 1'b1; step_nxt = ST_ID23; end
      ST_ID23: begin req_wide = 1'b1; req_addr = AW'(2); step_nxt = ST_ID4; end
      ST_ID4:  begin req_addr = AW'(4); step_nxt = ST_ID8; end
      ST_ID8:  begin req_addr = AW'(8); step_nxt = ST_FIN; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step          <= ST_RD0;
      busy          <= 1'b0;
      held          <= '0;
      vid           <= '0;
      dens          <= '0;
      lat_code      <= '0;
      init_done     <= 1'b0;
      init_err      <= 1'b0;
      phys_bytes    <= '0;
      rd_lat_cycles <= '0;
    end else if (req_start) begin
      busy <= 1'b1;
    end else if (busy && rsp_done) begin
      busy <= 1'b0;
      held <= rsp_rdata;
      step <= step_nxt;
      if (step == ST_ID01) begin
        vid      <= rsp_rdata[12:8];
        lat_code <= rsp_rdata[4:2];
      end
      if (step == ST_ID23) dens <= rsp_rdata[2:0];
      if (step == ST_ID8) begin
        init_done     <= 1'b1;
        init_err      <= (vid != VENDOR_ID);
        phys_bytes    <= (vid == VENDOR_ID) ? size_of(dens) : '0;
        rd_lat_cycles <= {1'b0, lat_code, 1'b0} + 5'd6;
      end
    end
  end

  assign avail_bytes = ECC_EN ? (phys_bytes - (phys_bytes >> 4)) : phys_bytes;

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    req_start |=> !req_start);
  a_r10_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);
  a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    init_err |=> init_err);
  a_r10_quiet_after: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> !req_start);
  a_r10_size_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (init_done && $past(init_done)) |-> $stable(phys_bytes));
  a_r6_err_done: assert property (@(posedge clk) disable iff (!rst_n)
    init_err |-> (init_done && phys_bytes == '0));
  a_r8_avail_bound: assert property (@(posedge clk) disable iff (!rst_n)
    avail_bytes <= phys_bytes);
  a_r2_cfg_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (req_start && req_write && req_wide) |-> (req_wdata[5:0] == CFG0_SET[5:0]));

endmodule

// File: tb/sim_psram_mr_init.sv
`timescale 1ns/1ps
module sim_psram_dev (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        wr,
  input  logic        wide,
  input  logic [7:0]  addr,
  input  logic [15:0] wdata,
  input  logic        stray,
  input  logic [7:0]  init0, init1, init2, init3, init4, init8,
  output logic        done,
  output logic [15:0] rdata,
  output logic [7:0]  r0, r1, r8,
  output logic [79:0] log_flat,
  output logic [7:0]  nstart,
  output logic [7:0]  overlap
);
  logic [7:0] mem [0:15];
  logic       pend;
  logic [2:0] dly;
  logic       c_wr, c_wide;
  logic [3:0] c_a;
  logic [15:0] c_d;
  assign r0 = mem[0];
  assign r1 = mem[1];
  assign r8 = mem[8];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) mem[i] <= 8'h00;
      mem[0] <= init0; mem[1] <= init1; mem[2] <= init2;
      mem[3] <= init3; mem[4] <= init4; mem[8] <= init8;
      pend <= 1'b0; dly <= '0; done <= 1'b0; rdata <= '0;
      log_flat <= '0; nstart <= '0; overlap <= '0;
      c_wr <= 1'b0; c_wide <= 1'b0; c_a <= '0; c_d <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        if (pend) overlap <= overlap + 8'd1;
        if (nstart < 8) log_flat[nstart*10 +: 10] <= {wr, wide, addr};
        nstart <= nstart + 8'd1;
        pend <= 1'b1;
        dly <= 3'($urandom % 4);
        c_wr <= wr; c_wide <= wide; c_a <= addr[3:0]; c_d <= wdata;
      end else if (pend) begin
        if (dly == 0) begin
          pend <= 1'b0;
          done <= 1'b1;
          if (c_wr) begin
            mem[c_a] <= c_d[7:0];
            if (c_wide) mem[c_a + 4'd1] <= c_d[15:8];
            rdata <= '0;
          end else begin
            rdata <= c_wide ? {mem[c_a + 4'd1], mem[c_a]} : {8'h00, mem[c_a]};
          end
        end else dly <= dly - 3'd1;
      end else if (stray) begin
        done <= 1'b1;
        rdata <= 16'hFFFF;
      end
    end
  end
endmodule

module sim_psram_mr_init;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  int tests = 0;
  int fails = 0;
  logic stray = 1'b0;
  logic [7:0] i0, i1, i2, i3, i4, i8;

  logic s0, w0, wd0, dn0, s1, w1, wd1, dn1;
  logic [7:0] a0, a1;
  logic [15:0] wdt0, rd0, wdt1, rd1;
  logic done0, err0, done1, err1;
  logic [31:0] ph0, av0, ph1, av1;
  logic [4:0] lat0, lat1;
  logic [7:0] m0r0, m0r1, m0r8, m1r0, m1r1, m1r8, ns0, ns1, ov0, ov1;
  logic [79:0] lg0, lg1;

  psram_mr_init u0 (.clk, .rst_n, .req_start(s0), .req_write(w0), .req_wide(wd0),
    .req_addr(a0), .req_wdata(wdt0), .rsp_done(dn0), .rsp_rdata(rd0),
    .init_done(done0), .init_err(err0), .phys_bytes(ph0), .avail_bytes(av0),
    .rd_lat_cycles(lat0));
  psram_mr_init #(.ECC_EN(1'b0)) u1 (.clk, .rst_n, .req_start(s1), .req_write(w1),
    .req_wide(wd1), .req_addr(a1), .req_wdata(wdt1), .rsp_done(dn1), .rsp_rdata(rd1),
    .init_done(done1), .init_err(err1), .phys_bytes(ph1), .avail_bytes(av1),
    .rd_lat_cycles(lat1));

  sim_psram_dev m0 (.clk, .rst_n, .start(s0), .wr(w0), .wide(wd0), .addr(a0), .wdata(wdt0),
    .stray, .init0(i0), .init1(i1), .init2(i2), .init3(i3), .init4(i4), .init8(i8),
    .done(dn0), .rdata(rd0), .r0(m0r0), .r1(m0r1), .r8(m0r8), .log_flat(lg0),
    .nstart(ns0), .overlap(ov0));
  sim_psram_dev m1 (.clk, .rst_n, .start(s1), .wr(w1), .wide(wd1), .addr(a1), .wdata(wdt1),
    .stray, .init0(i0), .init1(i1), .init2(i2), .init3(i3), .init4(i4), .init8(i8),
    .done(dn1), .rdata(rd1), .r0(m1r0), .r1(m1r1), .r8(m1r8), .log_flat(lg1),
    .nstart(ns1), .overlap(ov1));

  function automatic logic [31:0] exp_size(input logic [2:0] d);
    case (d)
      3'd1: return 32'd4194304;
      3'd3: return 32'd8388608;
      3'd5: return 32'd16777216;
      3'd7: return 32'd33554432;
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [4:0] ven, input logic [2:0] den);
    logic [31:0] ps, s_ph0, s_ph1;
    logic [79:0] ex0, ex1;
    i0 = 8'($urandom); i1 = {3'($urandom), ven}; i2 = {5'($urandom), den};
    i3 = 8'($urandom); i4 = 8'($urandom); i8 = 8'($urandom);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!done0 && !err0 && !done1 && !err1, "R1 flags in reset", {done0, err0, done1, err1}, 0);
    chk(ph0 == 0 && av0 == 0 && lat0 == 0 && ph1 == 0, "R1 sizes in reset", ph0 | av0 | lat0, 0);
    rst_n = 1'b1;
    for (int t = 0; t < 400 && !(done0 && done1); t++) @(negedge clk);
    chk(done0 && done1, "R10 completion", {done0, done1}, 2'b11);
    ex0 = {10'h008, 10'h004, 10'h102, 10'h100, 10'h208, 10'h008, 10'h300, 10'h100};
    ex1 = {20'h0, 10'h008, 10'h004, 10'h102, 10'h100, 10'h300, 10'h100};
    chk(lg0[9:0] == 10'h100, "R1 first access", lg0[9:0], 10'h100);
    chk(lg0[19:10] == 10'h300, "R2 write access", lg0[19:10], 10'h300);
    chk(m0r0 == {i0[7:6], 6'h28} && m1r0 == {i0[7:6], 6'h28}, "R2 reg0 value", m0r0, {i0[7:6], 6'h28});
    chk(m0r1 == i1 && m1r1 == i1, "R2 reg1 kept", m0r1, i1);
    chk(lg0[39:20] == {10'h208, 10'h008}, "R3 reg8 accesses", lg0[39:20], {10'h208, 10'h008});
    chk(m0r8 == {i8[7:3], 3'b011}, "R3 reg8 value", m0r8, {i8[7:3], 3'b011});
    chk(m1r8 == i8, "R3 reg8 untouched without ECC", m1r8, i8);
    chk(lg0 == ex0, "R4 order ECC", lg0[31:0], ex0[31:0]);
    chk(lg1 == ex1, "R4 order plain", lg1[31:0], ex1[31:0]);
    chk(ns0 == 8 && ns1 == 6 && ov0 == 0 && ov1 == 0, "R5 pulse count", {ns0, ns1, ov0}, {8'd8, 8'd6, 8'd0});
    ps = (ven == 5'hD) ? exp_size(den) : 32'd0;
    chk(err0 == (ven != 5'hD) && err1 == (ven != 5'hD), "R6 vendor check", {err0, err1}, {2{ven != 5'hD}});
    chk(ph0 == ps && ph1 == ps, "R7 size", ph0, ps);
    chk(av0 == ps - ps / 16, "R8 usable ECC", av0, ps - ps / 16);
    chk(av1 == ps, "R8 usable plain", av1, ps);
    chk(lat0 == 5'd10 && lat1 == 5'd10, "R9 latency", lat0, 10);
    s_ph0 = ph0; s_ph1 = ph1;
    stray = 1'b1;
    repeat (4) @(negedge clk);
    stray = 1'b0;
    repeat (3) @(negedge clk);
    chk(done0 && done1 && err0 == (ven != 5'hD) && ns0 == 8 && ns1 == 6,
        "R10 stray ignored", {ns0, ns1}, {8'd8, 8'd6});
    chk(ph0 == s_ph0 && ph1 == s_ph1 && lat0 == 5'd10, "R10 results held", ph0, s_ph0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int d = 0; d < 8; d++) run(5'hD, 3'(d));
    run(5'h0D ^ 5'h10, 3'd3);
    run(5'h00, 3'd7);
    for (int k = 0; k < 12; k++) run(($urandom % 4 == 0) ? 5'($urandom) : 5'hD, 3'($urandom));
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule